// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is the bus-facing front end of a four-channel digital potentiometer controller. It watches a two-wire serial bus (clock and open-drain data) by sampling both lines with the system clock. It finds START and STOP conditions and then receives a frame: an identification byte, an instruction byte and, for write commands, a data byte. It acknowledges each accepted byte by pulling the data line low, and it sends a read byte back to the bus master. The downstream register bank supplies that byte.

Each instruction is decoded into a one-hot command strobe. The strobe carries a data-register pointer and a channel pointer, plus the data byte for writes. While the downstream bank performs a non-volatile store, it raises a busy input, and the slave then refuses to acknowledge its address. The increment/decrement instruction switches the slave into stepping mode. In that mode every clock pulse on the bus becomes a single up or down step pulse for the selected channel. The mode ends at the next STOP or START.

Top module: `pot_bus_slave`

## Requirements
- R1: After reset, sda_low_o, cmd_strobe_o, step_mode_o, step_up_o and step_dn_o are all 0.
- R2: An identification byte, received MSB first, is acknowledged when its upper nibble is 0101 and its lower nibble equals strap_i. Acknowledging means sda_low_o is 1 during the ninth SCL high phase.
- R3: A frame whose identification byte does not match is ignored until the next START. No byte in it is acknowledged and no strobe is issued.
- R4: If nv_busy_i is 1 when the identification byte completes, that byte is not acknowledged and the rest of the frame is ignored.
- R5: The instruction byte layout is:
  - opcode in bits 7:4, register pointer in bits 3:2 (cmd_reg_o), channel pointer in bits 1:0 (cmd_chan_o).
  - Opcode to cmd_strobe_o bit: 1001→0, 1010→1, 1011→2, 1100→3, 1101→4, 1110→5, 0001→6, 1000→7, 0010→8.
  - A known opcode is acknowledged.
  - For every opcode other than 1010 and 1100, exactly one strobe bit pulses for one cycle once the instruction byte is complete.
- R6: An unknown opcode is not acknowledged and issues no strobe, and later bytes of the frame are ignored.
- R7: For opcodes 1010 and 1100, no strobe is issued after the instruction byte. The third byte, MSB first, is acknowledged, and the strobe is then issued with cmd_data_o equal to that byte.
- R8: For opcodes 1001 and 1011, the slave sends rd_data_i MSB first after the instruction acknowledge. The byte is captured at the SCL falling edge that ends the preceding acknowledge clock. A low master acknowledge starts another byte with a fresh capture. A high one (NACK) leaves SDA released.
- R9: After the acknowledge of opcode 0010, step_mode_o is 1. Each complete SCL high pulse then yields a one-cycle step_up_o if SDA was high during that pulse, or a one-cycle step_dn_o if SDA was low. The pulse appears at the SCL falling edge.
- R10: A STOP releases SDA and clears step_mode_o. A STOP inside the high phase of a stepping pulse yields no step.
- R11: A START in the middle of a frame abandons that frame, and the next byte is treated as an identification byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen on the wire (asynchronous) |
| sda_low_o | output | 1 | 1 pulls the open-drain data line low |
| strap_i | input | 4 | Pin-strapped low address nibble |
| nv_busy_i | input | 1 | Non-volatile store in progress downstream |
| rd_data_i | input | 8 | Byte to send on a read, from the register bank |
| cmd_strobe_o | output | 9 | One-hot, one-cycle command strobe |
| cmd_reg_o | output | 2 | Data-register pointer of the command |
| cmd_chan_o | output | 2 | Channel pointer of the command |
| cmd_data_o | output | 8 | Data byte of a write command |
| step_mode_o | output | 1 | Stepping mode active |
| step_up_o | output | 1 | One-cycle step toward the high end |
| step_dn_o | output | 1 | One-cycle step toward the low end |

## Verification
The delicate overlap is at the end of a stepping sequence. There, the rising SCL edge that prepares a step falls in the same high phase as the STOP that closes the frame, so step commit and frame termination compete. Every random stepping frame ends this way: the master raises SCL with SDA low and then raises SDA. The bench compares the up and down pulse counts before and after the STOP against the number of complete pulses it drove. It also checks that step_mode_o has dropped. A second overlap is busy assertion coinciding with completion of the address byte; random frames raise nv_busy_i over exactly that window and expect silence.

// File: rtl/pbs_pkg.sv
// Shared constants and types of the two-wire potentiometer command slave.
// Assumes 8-bit bytes and the fixed instruction-byte field layout below.
package pbs_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_CMD   = 9;
    localparam int CMD_IDX_W = 4;
    localparam int PTR_W     = 2;

    // instruction byte fields (the decoder depends on these positions)
    localparam int OPC_LSB = 4;
    localparam int REG_LSB = 2;
    localparam int CHN_LSB = 0;

    localparam logic [3:0] OPC_RD_WIPER   = 4'b1001;
    localparam logic [3:0] OPC_WR_WIPER   = 4'b1010;
    localparam logic [3:0] OPC_RD_DREG    = 4'b1011;
    localparam logic [3:0] OPC_WR_DREG    = 4'b1100;
    localparam logic [3:0] OPC_DREG_TO_W  = 4'b1101;
    localparam logic [3:0] OPC_W_TO_DREG  = 4'b1110;
    localparam logic [3:0] OPC_ALL_D_TO_W = 4'b0001;
    localparam logic [3:0] OPC_ALL_W_TO_D = 4'b1000;
    localparam logic [3:0] OPC_STEP       = 4'b0010;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_STEP
    } bus_state_e;

    typedef enum logic [1:0] {
        PH_ID, PH_INSTR, PH_DATA
    } byte_phase_e;

    typedef struct packed {
        logic                 known;
        logic                 has_data;
        logic                 is_read;
        logic                 is_step;
        logic [CMD_IDX_W-1:0] idx;
    } cmd_info_t;
endpackage

// File: rtl/pbs_sync_edge.sv
// Bus line synchronizer and condition detector.
// Brings SCL and SDA into the clk domain through SYNC_STAGES flops (>= 2),
// then flags SCL edges and START/STOP. Assumes each bus phase lasts several
// clk cycles, so no glitch filtering beyond the synchronizer is done.
module pbs_sync_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_s, scl_q, sda_q;

    // shift raw lines through the synchronizer and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // edges and bus conditions from the current and delayed samples
    always_comb begin
        scl_rise  = scl_s & ~scl_q;
        scl_fall  = ~scl_s & scl_q;
        start_det = scl_s & scl_q & sda_q & ~sda_s;
        stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    end
endmodule

// File: rtl/pbs_cmd_decode.sv
// Opcode decoder: maps the 4-bit opcode to a strobe index and frame shape
// (data byte follows, read-back, stepping). Unknown codes give known = 0.
module pbs_cmd_decode
    import pbs_pkg::*;
(
    input  logic [3:0] opcode,
    output cmd_info_t  info
);
    // table lookup of the command attributes
    always_comb begin
        info = '0;
        info.known = 1'b1;
        unique case (opcode)
            OPC_RD_WIPER:   begin info.idx = CMD_IDX_W'(0); info.is_read  = 1'b1; end
            OPC_WR_WIPER:   begin info.idx = CMD_IDX_W'(1); info.has_data = 1'b1; end
            OPC_RD_DREG:    begin info.idx = CMD_IDX_W'(2); info.is_read  = 1'b1; end
            OPC_WR_DREG:    begin info.idx = CMD_IDX_W'(3); info.has_data = 1'b1; end
            OPC_DREG_TO_W:  info.idx = CMD_IDX_W'(4);
            OPC_W_TO_DREG:  info.idx = CMD_IDX_W'(5);
            OPC_ALL_D_TO_W: info.idx = CMD_IDX_W'(6);
            OPC_ALL_W_TO_D: info.idx = CMD_IDX_W'(7);
            OPC_STEP:       begin info.idx = CMD_IDX_W'(8); info.is_step = 1'b1; end
            default:        info.known = 1'b0;
        endcase
    end
endmodule

// File: rtl/pbs_step_ctl.sv
// Stepping unit: while enabled, each complete SCL high pulse produces one
// step pulse whose direction is the SDA level seen at the rising edge.
// The step is committed at the falling edge, so a START or STOP inside
// the high phase (abort) cancels it.
module pbs_step_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic sda_s,
    input  logic abort,
    output logic step_up_o,
    output logic step_dn_o
);
    logic armed, dir_q;

    // arm on rise, commit on fall, cancel on abort or when disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            dir_q     <= 1'b0;
            step_up_o <= 1'b0;
            step_dn_o <= 1'b0;
        end else begin
            step_up_o <= 1'b0;
            step_dn_o <= 1'b0;
            if (!enable || abort) begin
                armed <= 1'b0;
            end else if (scl_rise) begin
                armed <= 1'b1;
                dir_q <= sda_s;
            end else if (scl_fall && armed) begin
                armed     <= 1'b0;
                step_up_o <= dir_q;
                step_dn_o <= ~dir_q;
            end
        end
    end

    // R9: a step pulse follows an SCL falling edge
    a_r9_step_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up_o || step_dn_o) |-> $past(scl_fall));

    // R10: a bus condition never yields a step in the next cycle
    a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !(step_up_o || step_dn_o));
endmodule

// File: rtl/pot_bus_slave.sv
// Two-wire bus slave for a quad potentiometer controller.
// Receives ID, instruction and optional data bytes, acknowledges them,
// sends read bytes, issues one-hot command strobes and hands bus clocking
// to the stepping unit. Assumes the bus is much slower than clk, that SDA
// changes only while SCL is low except for START/STOP, and no clock
// stretching or arbitration is needed.
module pot_bus_slave
    import pbs_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE    = 4'b0101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_low_o,
    input  logic [3:0]         strap_i,
    input  logic               nv_busy_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic [NUM_CMD-1:0] cmd_strobe_o,
    output logic [PTR_W-1:0]   cmd_reg_o,
    output logic [PTR_W-1:0]   cmd_chan_o,
    output logic [BYTE_W-1:0]  cmd_data_o,
    output logic               step_mode_o,
    output logic               step_up_o,
    output logic               step_dn_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    bus_state_e  state;
    byte_phase_e phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh, tx_sh, next_byte;
    logic [2*PTR_W-1:0] ptr_q;
    logic byte_full, ack_next, m_ack, id_ok;
    cmd_info_t info_now, info_q;

    pbs_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    pbs_cmd_decode u_dec (
        .opcode(next_byte[OPC_LSB +: 4]),
        .info(info_now)
    );

    pbs_step_ctl u_step (
        .clk(clk), .rst_n(rst_n), .enable(step_mode_o),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .abort(start_det | stop_det),
        .step_up_o(step_up_o), .step_dn_o(step_dn_o)
    );

    // byte as it will stand after the current sample, and address match
    assign next_byte   = {rx_sh[BYTE_W-2:0], sda_s};
    assign id_ok       = (next_byte == {DEV_TYPE, strap_i}) && !nv_busy_i;
    assign step_mode_o = (state == ST_STEP);

    // frame sequencer: receive, acknowledge, transmit and command strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            phase        <= PH_ID;
            cnt          <= '0;
            rx_sh        <= '0;
            tx_sh        <= '0;
            ptr_q        <= '0;
            byte_full    <= 1'b0;
            ack_next     <= 1'b0;
            m_ack        <= 1'b0;
            info_q       <= '0;
            sda_low_o    <= 1'b0;
            cmd_strobe_o <= '0;
            cmd_reg_o    <= '0;
            cmd_chan_o   <= '0;
            cmd_data_o   <= '0;
        end else begin
            cmd_strobe_o <= '0;
            if (start_det) begin
                state     <= ST_RX;
                phase     <= PH_ID;
                cnt       <= '0;
                byte_full <= 1'b0;
                sda_low_o <= 1'b0;
            end else if (stop_det) begin
                state     <= ST_IDLE;
                byte_full <= 1'b0;
                sda_low_o <= 1'b0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            rx_sh <= next_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                byte_full <= 1'b1;
                                unique case (phase)
                                    PH_ID: ack_next <= id_ok;
                                    PH_INSTR: begin
                                        ack_next <= info_now.known;
                                        info_q   <= info_now;
                                        ptr_q    <= next_byte[2*PTR_W-1:0];
                                        if (info_now.known && !info_now.has_data) begin
                                            cmd_strobe_o <= NUM_CMD'(1) << info_now.idx;
                                            cmd_reg_o    <= next_byte[REG_LSB +: PTR_W];
                                            cmd_chan_o   <= next_byte[CHN_LSB +: PTR_W];
                                        end
                                    end
                                    default: begin
                                        ack_next     <= 1'b1;
                                        cmd_strobe_o <= NUM_CMD'(1) << info_q.idx;
                                        cmd_reg_o    <= ptr_q[REG_LSB +: PTR_W];
                                        cmd_chan_o   <= ptr_q[CHN_LSB +: PTR_W];
                                        cmd_data_o   <= next_byte;
                                    end
                                endcase
                            end
                        end else if (scl_fall && byte_full) begin
                            byte_full <= 1'b0;
                            if (ack_next) begin
                                sda_low_o <= 1'b1;
                                state     <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            sda_low_o <= 1'b0;
                            unique case (phase)
                                PH_ID: begin
                                    phase <= PH_INSTR;
                                    state <= ST_RX;
                                end
                                PH_INSTR: begin
                                    if (info_q.known && info_q.has_data) begin
                                        phase <= PH_DATA;
                                        state <= ST_RX;
                                    end else if (info_q.is_read) begin
                                        tx_sh     <= rd_data_i;
                                        sda_low_o <= ~rd_data_i[BYTE_W-1];
                                        cnt       <= '0;
                                        state     <= ST_TX;
                                    end else if (info_q.is_step) begin
                                        state <= ST_STEP;
                                    end else begin
                                        state <= ST_IDLE;
                                    end
                                end
                                default: state <= ST_IDLE;
                            endcase
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == LAST_BIT) begin
                                sda_low_o <= 1'b0;
                                cnt       <= '0;
                                state     <= ST_TXACK;
                            end else begin
                                cnt       <= cnt + 1'b1;
                                tx_sh     <= tx_sh << 1;
                                sda_low_o <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            m_ack <= ~sda_s;
                        end else if (scl_fall) begin
                            if (m_ack) begin
                                tx_sh     <= rd_data_i;
                                sda_low_o <= ~rd_data_i[BYTE_W-1];
                                state     <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: never more than one command strobe at a time
    a_r5_onehot_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe_o));

    // R10: a STOP releases the data line and leaves stepping mode
    a_r10_stop_release: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_low_o && !step_mode_o));

    // R11: a START releases the data line and leaves stepping mode
    a_r11_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!sda_low_o && !step_mode_o));

    // R8: while sending, the driven bit changes only after SCL falls
    a_r8_tx_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && $past(state) == ST_TX && sda_low_o != $past(sda_low_o))
        |-> $past(scl_fall));
endmodule

// File: tb/pot_bus_slave_bench.sv
// Self-checking bench: a bus-master model driving directed and random frames.
module pot_bus_slave_bench;
    localparam int Q = 8;   // clk cycles per bus quarter phase

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1, bus_sda;
    logic [3:0] strap = 4'h0;
    logic nv_busy = 1'b0;
    logic [7:0] rd_data = 8'h00;
    logic sda_low_o, step_mode_o, step_up_o, step_dn_o;
    logic [8:0] cmd_strobe_o;
    logic [1:0] cmd_reg_o, cmd_chan_o;
    logic [7:0] cmd_data_o;
    int n_chk = 0, n_bad = 0, n_cmd = 0, n_up = 0, n_dn = 0;
    logic [8:0] last_mask = '0;
    logic [1:0] last_reg = '0, last_chan = '0;
    logic [7:0] last_data = '0;
    bit done = 0;

    always #4 clk = ~clk;
    assign bus_sda = m_sda & ~sda_low_o;

    pot_bus_slave u_pot_bus_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
        .sda_low_o(sda_low_o), .strap_i(strap), .nv_busy_i(nv_busy),
        .rd_data_i(rd_data), .cmd_strobe_o(cmd_strobe_o), .cmd_reg_o(cmd_reg_o),
        .cmd_chan_o(cmd_chan_o), .cmd_data_o(cmd_data_o), .step_mode_o(step_mode_o),
        .step_up_o(step_up_o), .step_dn_o(step_dn_o)
    );

    // record strobes and step pulses away from the active edge
    always @(negedge clk) if (rst_n) begin
        if (cmd_strobe_o != 0) begin
            n_cmd++; last_mask = cmd_strobe_o; last_reg = cmd_reg_o;
            last_chan = cmd_chan_o; last_data = cmd_data_o;
        end
        if (step_up_o) n_up++;
        if (step_dn_o) n_dn++;
    end

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_idx(input logic [3:0] op);
        case (op)
            4'b1001: return 0; 4'b1010: return 1; 4'b1011: return 2;
            4'b1100: return 3; 4'b1101: return 4; 4'b1110: return 5;
            4'b0001: return 6; 4'b1000: return 7; 4'b0010: return 8;
            default: return -1;
        endcase
    endfunction

    function automatic logic [3:0] op_of(input int k);
        case (k)
            0: return 4'b1001; 1: return 4'b1010; 2: return 4'b1011;
            3: return 4'b1100; 4: return 4'b1101; 5: return 4'b1110;
            6: return 4'b0001; 7: return 4'b1000; default: return 4'b0010;
        endcase
    endfunction

    task automatic bus_start();
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
        m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask

    task automatic clock_bit(input logic b);
        m_sda = b; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) clock_bit(b[i]);
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q / 2);
        ack = sda_low_o; wq(Q / 2); m_scl = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic nack, input logic [7:0] nxt);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); m_scl = 1'b1; wq(Q / 2); b[i] = bus_sda;
            wq(Q / 2); m_scl = 1'b0;
        end
        rd_data = nxt; m_sda = nack; wq(Q);
        m_scl = 1'b1; wq(Q); m_scl = 1'b0; wq(2); m_sda = 1'b1; wq(Q - 2);
    endtask

    // one complete frame with expectations derived from the requirements
    task automatic do_frame(input logic [7:0] idb, input logic [7:0] ins, input bit busy);
        logic ack, exp_id;
        logic [7:0] dat, rda, rdb, got;
        int idx, base, u0, d0, eu, ed, n;
        bit is_step;
        base = n_cmd; is_step = 0; eu = 0; ed = 0; u0 = 0; d0 = 0;
        exp_id = (idb == {4'b0101, strap}) && !busy;
        rda = 8'($urandom); rd_data = rda;
        bus_start();
        nv_busy = busy; send_byte(idb, ack); nv_busy = 1'b0;
        chk(ack == exp_id, exp_id ? "R2 id ack" : (busy ? "R4 busy silence" : "R3 id mismatch"),
            ack, exp_id);
        if (!exp_id) begin
            send_byte(ins, ack);
            chk(!ack, busy ? "R4 later byte" : "R3 later byte", ack, 0);
            chk(n_cmd == base, busy ? "R4 no strobe" : "R3 no strobe", n_cmd - base, 0);
        end else begin
            idx = exp_idx(ins[7:4]);
            send_byte(ins, ack);
            chk(ack == (idx >= 0), idx >= 0 ? "R5 opcode ack" : "R6 unknown ack", ack, idx >= 0);
            if (idx < 0) begin
                send_byte(8'($urandom), ack);
                chk(!ack, "R6 later byte", ack, 0);
                chk(n_cmd == base, "R6 no strobe", n_cmd - base, 0);
            end else if (idx == 1 || idx == 3) begin
                chk(n_cmd == base, "R7 no early strobe", n_cmd - base, 0);
                dat = 8'($urandom); send_byte(dat, ack);
                chk(ack, "R7 data ack", ack, 1);
                chk(n_cmd == base + 1 && last_mask == (9'd1 << idx), "R7 strobe", last_mask, 1 << idx);
                chk(last_data == dat && last_reg == ins[3:2] && last_chan == ins[1:0],
                    "R7 data/pointers", {last_data, last_reg, last_chan}, {dat, ins[3:0]});
            end else begin
                chk(n_cmd == base + 1 && last_mask == (9'd1 << idx), "R5 strobe", last_mask, 1 << idx);
                chk(last_reg == ins[3:2] && last_chan == ins[1:0], "R5 pointers",
                    {last_reg, last_chan}, ins[3:0]);
                if (idx == 0 || idx == 2) begin
                    rdb = 8'($urandom);
                    recv_byte(got, 1'b0, rdb);
                    chk(got == rda, "R8 first byte", got, rda);
                    recv_byte(got, 1'b1, 8'($urandom));
                    chk(got == rdb, "R8 second byte", got, rdb);
                    m_scl = 1'b1; wq(Q / 2);
                    chk(!sda_low_o, "R8 released after NACK", sda_low_o, 0);
                    wq(Q / 2); m_scl = 1'b0; wq(Q);
                end else if (idx == 8) begin
                    is_step = 1;
                    chk(step_mode_o, "R9 step mode", step_mode_o, 1);
                    u0 = n_up; d0 = n_dn; n = 1 + int'($urandom % 6);
                    for (int k = 0; k < n; k++) begin
                        logic dir;
                        dir = 1'($urandom);
                        clock_bit(dir);
                        if (dir) eu++; else ed++;
                    end
                    chk(n_up - u0 == eu, "R9 up steps", n_up - u0, eu);
                    chk(n_dn - d0 == ed, "R9 down steps", n_dn - d0, ed);
                end
            end
        end
        bus_stop(); wq(Q);
        if (is_step) begin
            chk(n_up - u0 == eu && n_dn - d0 == ed, "R10 no step at STOP",
                (n_up - u0) + (n_dn - d0), eu + ed);
            chk(!step_mode_o, "R10 step mode cleared", step_mode_o, 0);
        end
        chk(!sda_low_o, "R10 line released", sda_low_o, 0);
    endtask

    initial begin
        logic ack;
        void'($urandom(32'd20240917));
        wq(5);
        chk(!sda_low_o && cmd_strobe_o == 0 && !step_mode_o && !step_up_o && !step_dn_o,
            "R1 reset outputs", {sda_low_o, step_mode_o, step_up_o, step_dn_o}, 0);
        rst_n = 1'b1; wq(5);
        chk(!sda_low_o && cmd_strobe_o == 0 && !step_mode_o, "R1 after release",
            {sda_low_o, step_mode_o}, 0);

        strap = 4'hA;
        do_frame({4'b0101, 4'hA}, {4'b1101, 4'b0110}, 1'b1);   // R4 busy
        do_frame({4'b0101, 4'h3}, {4'b1101, 4'b0110}, 1'b0);   // R3 wrong strap
        do_frame({4'b0111, 4'hA}, {4'b1101, 4'b0110}, 1'b0);   // R3 wrong type
        do_frame({4'b0101, 4'hA}, {4'b0000, 4'b1111}, 1'b0);   // R6
        for (int k = 0; k < 9; k++)
            do_frame({4'b0101, strap}, {op_of(k), 4'($urandom)}, 1'b0);

        // R11: START in the middle of the instruction byte
        bus_start(); send_byte({4'b0101, strap}, ack);
        for (int i = 0; i < 4; i++) clock_bit(1'b1);
        begin
            int base;
            base = n_cmd;
            bus_start(); send_byte({4'b0101, strap}, ack);
            chk(ack, "R11 restart id ack", ack, 1);
            send_byte({4'b1110, 4'b0110}, ack);
            chk(ack && n_cmd == base + 1 && last_mask == 9'd1 << 5 && last_reg == 2'b01
                && last_chan == 2'b10, "R11 restarted command", last_mask, 1 << 5);
            bus_stop(); wq(Q);
        end

        for (int it = 0; it < 40; it++) begin
            logic [7:0] idb, ins;
            bit busy;
            strap = 4'($urandom);
            busy = ($urandom % 6) == 0;
            idb = ($urandom % 5 == 0) ? 8'($urandom) : {4'b0101, strap};
            ins = ($urandom % 4 == 0) ? 8'($urandom)
                                      : {op_of(int'($urandom % 9)), 4'($urandom)};
            do_frame(idb, ins, busy);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule